// File: doc/BRIEF.md
# Segmented Address Decoder with Mirror Folding

This block sits between a 32-bit CPU bus master and its memory targets. For each access it classifies the address into one of five regions: main RAM, boot ROM, scratchpad, the I/O register page or the cache-control page. It also returns an offset local to that region. Mirror addresses are folded onto the same physical location, so the targets only ever see a local offset. An address that matches no region is flagged as unmapped. A read of an unmapped address returns zero, and a write to one is dropped.

The block holds one bit of state, the RAM write isolation flag. Specific values written to the cache-control register at page offset 0x130 set or clear it. While the flag is set, writes to any RAM mirror are suppressed and RAM reads still work. Decoding is purely combinational.

The access side is a valid/ready pass-through. `out_valid` follows `in_valid` and `in_ready` follows `out_ready`, so back-pressure from the target reaches the master in the same cycle and the block adds no latency. An access counts as accepted only in a cycle where `in_valid` and `out_ready` are both high. The isolation flag can change only on an accepted write. The master must hold the address and data stable while `in_valid` is high and `out_ready` is low.

Top module: `seg_addr_decoder`

## Requirements
- R1: Addresses whose bits [31:23] equal 0x000, 0x100 or 0x140 select RAM (rgn_sel bit 0). The offset is the address modulo 0x200000, so all four 2 MiB copies in each 8 MiB window fold together.
- R2: Addresses whose bits [31:19] equal 0x3F8 or 0x17F8 select boot ROM (rgn_sel bit 1) with offset equal to the address modulo 0x80000. Writes there never raise rgn_wr_en.
- R3: The 4 KiB page 0x1F800xxx selects scratchpad (rgn_sel bit 2) with offset equal to address bits [11:0]. Reads and writes are both allowed.
- R4: The 4 KiB page 0x1F801xxx selects the I/O page (rgn_sel bit 3) with offset equal to address bits [11:0]. Writes are allowed.
- R5: Any other address, apart from the cache-control page, gives rgn_unmapped=1, rgn_sel=0, rgn_off=0 and rgn_wr_en=0, and rsp_rdata is zero.
- R6: rgn_sel has at most one bit set. For RAM, ROM, scratchpad and I/O reads, rsp_rdata equals tgt_rdata.
- R7: An accepted write of 0x800 or 0x804 to 0xFFFE0130 sets the isolation flag from the next cycle onward.
- R8: An accepted write of 0x0 or 0x1E988 to 0xFFFE0130 clears the flag. A write of any other value to that address leaves the flag as it was.
- R9: While the flag is set, RAM writes in all three windows give rgn_wr_en=0. RAM reads still select RAM with the correct offset, and scratchpad and I/O writes are unaffected.
- R10: The page 0xFFFE0xxx selects the cache-control region (rgn_sel bit 4). Its reads return zero, and writes to any offset other than 0x130 leave the flag unchanged.
- R11: After reset the flag is clear, so RAM writes raise rgn_wr_en.
- R12: out_valid equals in_valid and in_ready equals out_ready. A control write offered while out_ready is low does not change the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Master offers an access |
| in_ready | output | 1 | Access accepted this cycle (follows out_ready) |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 32 | Byte address |
| acc_wdata | input | 32 | Write data |
| out_valid | output | 1 | Decoded access valid toward targets |
| out_ready | input | 1 | Targets can take the access |
| rgn_sel | output | 5 | One-hot region: bit0 RAM, bit1 ROM, bit2 scratchpad, bit3 I/O, bit4 cache-control |
| rgn_off | output | 23 | Region-local offset |
| rgn_unmapped | output | 1 | No region matched |
| rgn_wr_en | output | 1 | Write is to be committed by the selected target |
| tgt_rdata | input | 32 | Read data from the selected target |
| rsp_rdata | output | 32 | Read data returned to the master |

## Verification
Two functions can meet in one cycle: the isolation flag changes on a clock edge, and the decode of a RAM write in the next cycle depends on the new flag. The bench makes an accepted control write and then, in the cycle right after, offers RAM writes in each window. It judges the result by rgn_wr_en against a flag value that it tracks itself. Full sweeps of all 4096 values of address bits [31:20] are run with the flag clear and again with it set, so every window edge meets both flag states. Accepted and refused control writes are interleaved to show that only accepted transfers move the flag.

// File: rtl/seg_dec_pkg.sv
package seg_dec_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int OFF_W  = 23;
  localparam int RGN_N  = 5;

  localparam int RG_RAM  = 0;
  localparam int RG_ROM  = 1;
  localparam int RG_SPAD = 2;
  localparam int RG_IO   = 3;
  localparam int RG_CCTL = 4;

  localparam int NUM_RAM_WIN = 3;
  localparam int NUM_ROM_WIN = 2;

  function automatic logic [ADDR_W-1:0] ram_win_base(int idx);
    case (idx)
      0:       return 32'h0000_0000;
      1:       return 32'h8000_0000;
      default: return 32'hA000_0000;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] rom_win_base(int idx);
    case (idx)
      0:       return 32'h1FC0_0000;
      default: return 32'hBFC0_0000;
    endcase
  endfunction

  localparam logic [ADDR_W-1:0] SPAD_BASE = 32'h1F80_0000;
  localparam logic [ADDR_W-1:0] IO_BASE   = 32'h1F80_1000;
  localparam logic [ADDR_W-1:0] CCTL_BASE = 32'hFFFE_0000;
endpackage

// File: rtl/seg_win_match.sv
module seg_win_match
  import seg_dec_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BASE = '0,
  parameter int SPAN_LOG2  = 12,
  parameter int LOCAL_LOG2 = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [OFF_W-1:0]  off
);
  assign hit = (addr[ADDR_W-1:SPAN_LOG2] == BASE[ADDR_W-1:SPAN_LOG2]);

  always_comb begin
    off = '0;
    off[LOCAL_LOG2-1:0] = addr[LOCAL_LOG2-1:0];
  end
endmodule

// File: rtl/seg_iso_ctrl.sv
module seg_iso_ctrl
  import seg_dec_pkg::*;
#(
  parameter int PAGE_LOG2 = 12,
  parameter logic [PAGE_LOG2-1:0] REG_OFF = 12'h130,
  parameter logic [DATA_W-1:0] ON_A  = 32'h0000_0800,
  parameter logic [DATA_W-1:0] ON_B  = 32'h0000_0804,
  parameter logic [DATA_W-1:0] OFF_A = 32'h0000_0000,
  parameter logic [DATA_W-1:0] OFF_B = 32'h0001_E988
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_fire,
  input  logic                 page_hit,
  input  logic [PAGE_LOG2-1:0] page_off,
  input  logic [DATA_W-1:0]    wdata,
  output logic                 iso_q
);
  logic reg_hit;
  assign reg_hit = wr_fire && page_hit && (page_off == REG_OFF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iso_q <= 1'b0;
    end else if (reg_hit) begin
      if (wdata == ON_A || wdata == ON_B)
        iso_q <= 1'b1;
      else if (wdata == OFF_A || wdata == OFF_B)
        iso_q <= 1'b0;
    end
  end
endmodule

// File: rtl/seg_addr_decoder.sv
module seg_addr_decoder
  import seg_dec_pkg::*;
#(
  parameter int RAM_LOG2     = 21,
  parameter int RAM_WIN_LOG2 = 23,
  parameter int ROM_LOG2     = 19,
  parameter int PAGE_LOG2    = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic               acc_write,
  input  logic [ADDR_W-1:0]  acc_addr,
  input  logic [DATA_W-1:0]  acc_wdata,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [RGN_N-1:0]   rgn_sel,
  output logic [OFF_W-1:0]   rgn_off,
  output logic               rgn_unmapped,
  output logic               rgn_wr_en,
  input  logic [DATA_W-1:0]  tgt_rdata,
  output logic [DATA_W-1:0]  rsp_rdata
);
  logic [NUM_RAM_WIN-1:0] ram_hit_w;
  logic [OFF_W-1:0]       ram_off_w [NUM_RAM_WIN];
  logic [NUM_ROM_WIN-1:0] rom_hit_w;
  logic [OFF_W-1:0]       rom_off_w [NUM_ROM_WIN];
  logic                   spad_hit, io_hit, cctl_hit;
  logic [OFF_W-1:0]       spad_off, io_off, cctl_off;
  logic [OFF_W-1:0]       ram_off, rom_off;
  logic                   iso_q;
  logic                   wr_fire;

  for (genvar g = 0; g < NUM_RAM_WIN; g++) begin : g_ram
    seg_win_match #(
      .BASE(ram_win_base(g)), .SPAN_LOG2(RAM_WIN_LOG2), .LOCAL_LOG2(RAM_LOG2)
    ) u_win (.addr(acc_addr), .hit(ram_hit_w[g]), .off(ram_off_w[g]));
  end

  for (genvar g = 0; g < NUM_ROM_WIN; g++) begin : g_rom
    seg_win_match #(
      .BASE(rom_win_base(g)), .SPAN_LOG2(ROM_LOG2), .LOCAL_LOG2(ROM_LOG2)
    ) u_win (.addr(acc_addr), .hit(rom_hit_w[g]), .off(rom_off_w[g]));
  end

  seg_win_match #(.BASE(SPAD_BASE), .SPAN_LOG2(PAGE_LOG2), .LOCAL_LOG2(PAGE_LOG2))
    u_spad (.addr(acc_addr), .hit(spad_hit), .off(spad_off));
  seg_win_match #(.BASE(IO_BASE), .SPAN_LOG2(PAGE_LOG2), .LOCAL_LOG2(PAGE_LOG2))
    u_io (.addr(acc_addr), .hit(io_hit), .off(io_off));
  seg_win_match #(.BASE(CCTL_BASE), .SPAN_LOG2(PAGE_LOG2), .LOCAL_LOG2(PAGE_LOG2))
    u_cctl (.addr(acc_addr), .hit(cctl_hit), .off(cctl_off));

  // Mirror folding: all windows of one region share the same local bits.
  always_comb begin
    ram_off = '0;
    for (int i = 0; i < NUM_RAM_WIN; i++)
      if (ram_hit_w[i]) ram_off = ram_off | ram_off_w[i];
    rom_off = '0;
    for (int i = 0; i < NUM_ROM_WIN; i++)
      if (rom_hit_w[i]) rom_off = rom_off | rom_off_w[i];
  end

  assign in_ready  = out_ready;
  assign out_valid = in_valid;
  assign wr_fire   = in_valid && out_ready && acc_write;

  seg_iso_ctrl #(.PAGE_LOG2(PAGE_LOG2)) u_iso (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .page_hit(cctl_hit),
    .page_off(cctl_off[PAGE_LOG2-1:0]), .wdata(acc_wdata), .iso_q(iso_q)
  );

  always_comb begin
    rgn_sel = '0;
    rgn_sel[RG_RAM]  = |ram_hit_w;
    rgn_sel[RG_ROM]  = |rom_hit_w;
    rgn_sel[RG_SPAD] = spad_hit;
    rgn_sel[RG_IO]   = io_hit;
    rgn_sel[RG_CCTL] = cctl_hit;
  end

  assign rgn_unmapped = ~|rgn_sel;

  always_comb begin
    rgn_off = '0;
    if (rgn_sel[RG_RAM])       rgn_off = ram_off;
    else if (rgn_sel[RG_ROM])  rgn_off = rom_off;
    else if (rgn_sel[RG_SPAD]) rgn_off = spad_off;
    else if (rgn_sel[RG_IO])   rgn_off = io_off;
    else if (rgn_sel[RG_CCTL]) rgn_off = cctl_off;
  end

  always_comb begin
    rgn_wr_en = 1'b0;
    if (acc_write) begin
      if (rgn_sel[RG_RAM])                      rgn_wr_en = !iso_q;
      else if (rgn_sel[RG_SPAD] || rgn_sel[RG_IO]) rgn_wr_en = 1'b1;
    end
  end

  assign rsp_rdata = (|rgn_sel[RG_IO:RG_RAM]) ? tgt_rdata : '0;
endmodule

// File: rtl/seg_addr_decoder_chk.sv
module seg_addr_decoder_chk
  import seg_dec_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              out_ready,
  input logic              acc_write,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [DATA_W-1:0] acc_wdata,
  input logic [RGN_N-1:0]  rgn_sel,
  input logic              rgn_unmapped,
  input logic              rgn_wr_en,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              iso_q
);
  logic ctl_fire;
  assign ctl_fire = in_valid && out_ready && acc_write && rgn_sel[RG_CCTL]
                    && (acc_addr[11:0] == 12'h130);

  // R6
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rgn_sel));

  // R5
  unmapped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rgn_unmapped |-> (rsp_rdata == '0 && !rgn_wr_en && rgn_sel == '0));

  // R2
  rom_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rgn_sel[RG_ROM] |-> !rgn_wr_en);

  // R9
  ram_iso_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iso_q && rgn_sel[RG_RAM]) |-> !rgn_wr_en);

  // R7
  iso_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_fire && (acc_wdata == 32'h800 || acc_wdata == 32'h804)) |=> iso_q);

  // R8
  iso_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_fire && (acc_wdata == 32'h0 || acc_wdata == 32'h1E988)) |=> !iso_q);

  // R12
  iso_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_fire |=> $stable(iso_q));

  // R11
  iso_reset_chk: assert property (@(posedge clk)
    !rst_n |=> !iso_q);
endmodule

bind seg_addr_decoder seg_addr_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_ready(out_ready),
  .acc_write(acc_write), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
  .rgn_sel(rgn_sel), .rgn_unmapped(rgn_unmapped), .rgn_wr_en(rgn_wr_en),
  .rsp_rdata(rsp_rdata), .iso_q(iso_q)
);

// File: tb/seg_addr_decoder_test.sv
module seg_addr_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, acc_write, out_valid, out_ready;
  logic [31:0] acc_addr, acc_wdata, tgt_rdata, rsp_rdata;
  logic [4:0]  rgn_sel;
  logic [22:0] rgn_off;
  logic        rgn_unmapped, rgn_wr_en;

  int n_run  = 0;
  int n_fail = 0;
  bit model_iso = 1'b0;

  always #2.5 clk = ~clk;

  seg_addr_decoder uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .acc_write(acc_write), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .out_valid(out_valid), .out_ready(out_ready), .rgn_sel(rgn_sel),
    .rgn_off(rgn_off), .rgn_unmapped(rgn_unmapped), .rgn_wr_en(rgn_wr_en),
    .tgt_rdata(tgt_rdata), .rsp_rdata(rsp_rdata)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Independent model of the address map.
  function automatic void model(input logic [31:0] a, input bit wr, input bit iso,
                                output logic [4:0] sel, output logic [22:0] off,
                                output bit we, output string tag);
    sel = '0; off = '0; we = 1'b0; tag = "R5";
    if (a[31:23] == 9'h000 || a[31:23] == 9'h100 || a[31:23] == 9'h140) begin
      sel = 5'b00001; off = {2'b0, a[20:0]}; we = wr && !iso; tag = iso ? "R9" : "R1";
    end else if (a[31:19] == 13'h03F8 || a[31:19] == 13'h17F8) begin
      sel = 5'b00010; off = {4'b0, a[18:0]}; tag = "R2";
    end else if (a[31:12] == 20'h1F800) begin
      sel = 5'b00100; off = {11'b0, a[11:0]}; we = wr; tag = "R3";
    end else if (a[31:12] == 20'h1F801) begin
      sel = 5'b01000; off = {11'b0, a[11:0]}; we = wr; tag = "R4";
    end else if (a[31:12] == 20'hFFFE0) begin
      sel = 5'b10000; off = {11'b0, a[11:0]}; tag = "R10";
    end
  endfunction

  task automatic probe(input logic [31:0] a, input bit wr, input bit rdy);
    logic [4:0] es; logic [22:0] eo; bit ew; string tg;
    logic [31:0] erd;
    in_valid = 1'b1; acc_write = wr; acc_addr = a; out_ready = rdy;
    acc_wdata = 32'h0000_1234;
    #1;
    model(a, wr, model_iso, es, eo, ew, tg);
    erd = (es[3:0] != 0) ? tgt_rdata : 32'h0;
    chk(rgn_sel == es && rgn_off == eo && rgn_unmapped == (es == 0)
        && rgn_wr_en == ew && rsp_rdata == erd && out_valid && in_ready == rdy,
        tg, $sformatf("decode @%h sel/off/we", a),
        {rgn_sel, rgn_unmapped, rgn_wr_en, rgn_off[22:0], 2'b0},
        {es, (es == 0), ew, eo, 2'b0});
  endtask

  task automatic sweep(input bit writes_only);
    logic [19:0] lows [7] = '{20'h00000, 20'h00FFC, 20'h01234, 20'hFFFFF,
                              20'h00130, 20'hE0130, 20'h7FFFF};
    for (int h = 0; h < 4096; h++)
      for (int k = 0; k < 7; k++) begin
        if (!writes_only) probe({h[11:0], lows[k]}, 1'b0, h[0]);
        probe({h[11:0], lows[k]}, 1'b1, 1'b0);
      end
  endtask

  // Offer one transfer for one clock edge.
  task automatic xfer(input logic [31:0] a, input logic [31:0] d, input bit wr,
                      input bit rdy);
    @(negedge clk);
    in_valid = 1'b1; acc_write = wr; acc_addr = a; acc_wdata = d; out_ready = rdy;
    @(posedge clk);
    #1 in_valid = 1'b0; out_ready = 1'b0;
  endtask

  task automatic check_iso(input bit exp, input string req);
    logic [31:0] wins [3] = '{32'h0000_0010, 32'h8060_0010, 32'hA07F_FFFC};
    for (int w = 0; w < 3; w++) begin
      acc_write = 1'b1; acc_addr = wins[w]; in_valid = 1'b0;
      #1;
      chk(rgn_wr_en == !exp && rgn_sel == 5'b00001, req,
          $sformatf("RAM write enable @%h", wins[w]), rgn_wr_en, !exp);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; acc_write = 1'b0; acc_addr = '0;
    acc_wdata = '0; out_ready = 1'b0; tgt_rdata = 32'hA5C3_5A3C;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R11: reset leaves RAM writable
    check_iso(1'b0, "R11");

    // R1 R2 R3 R4 R5 R6 R10 R12: full high-bit sweep, flag clear
    sweep(1'b0);
    check_iso(1'b0, "R12");

    // R7: enter with 0x800, RAM write blocked in the very next cycle
    xfer(32'hFFFE_0130, 32'h800, 1'b1, 1'b1); model_iso = 1'b1;
    check_iso(1'b1, "R7");
    // R9: sweep writes while isolated
    sweep(1'b1);
    probe(32'h8012_3456, 1'b0, 1'b1);
    // R8: other values leave the flag alone
    xfer(32'hFFFE_0130, 32'h0000_1234, 1'b1, 1'b1);
    check_iso(1'b1, "R8");
    // R10: other offset in the control page
    xfer(32'hFFFE_0134, 32'h0, 1'b1, 1'b1);
    check_iso(1'b1, "R10");
    // R12: refused transfer does not act
    xfer(32'hFFFE_0130, 32'h0, 1'b1, 1'b0);
    check_iso(1'b1, "R12");
    // R10: a read of the register with a leave value does nothing
    xfer(32'hFFFE_0130, 32'h0, 1'b0, 1'b1);
    check_iso(1'b1, "R10");
    // R8: leave with 0x1E988
    xfer(32'hFFFE_0130, 32'h1E988, 1'b1, 1'b1); model_iso = 1'b0;
    check_iso(1'b0, "R8");
    // R7: enter with 0x804, then R8 leave with 0
    xfer(32'hFFFE_0130, 32'h804, 1'b1, 1'b1); model_iso = 1'b1;
    check_iso(1'b1, "R7");
    xfer(32'hFFFE_0130, 32'h0, 1'b1, 1'b1); model_iso = 1'b0;
    check_iso(1'b0, "R8");
    // R9 scratchpad and I/O writes still go through when isolated
    xfer(32'hFFFE_0130, 32'h800, 1'b1, 1'b1); model_iso = 1'b1;
    probe(32'h1F80_0FFC, 1'b1, 1'b0);
    probe(32'h1F80_1070, 1'b1, 1'b0);
    // R11: reset clears the flag
    @(negedge clk); rst_n = 1'b0; in_valid = 1'b0;
    @(posedge clk); #1 rst_n = 1'b1; model_iso = 1'b0;
    check_iso(1'b0, "R11");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule